// File: doc/BRIEF.md
# Power-On Strap Latch and Frequency Mode Select

This block sits beside the output pads of a clock generator. Some of those pads do double duty: while power-on reset is held they are only read as configuration straps, and once reset is over they drive clocks. After reset is released, the block samples the strap values once into an internal latch. One reference clock later it asserts the output enables of those pads. The latched bits keep their value until power-on reset is asserted again.

A separate live select input is never latched. It passes through a synchronizer and forms the least significant bit of a mode code, with the latched straps above it, so the frequency mode can be switched at run time without a reset. One code value selects a production test mode. In that mode the block produces reference-derived clocks: the reference itself passed through a glitch-free gate, a half-rate clock and a quarter-rate clock. Outside test mode all of these are held low.

Top module: `strap_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `pad_oe`, `test_mode`, `tclk_div` and `tclk_ref` are all 0.
- R2: Reset release passes through a two-flop synchronizer. The straps are sampled on the third rising edge of `clk_ref` after `rst_n` rises, giving `mode_code[2]` = `strap_pad_in[1]` and `mode_code[1]` = `strap_pad_in[0]`. Before that edge these two bits read 0.
- R3: Every bit of `pad_oe` goes to 1 on the rising edge that follows the strap capture, which is the fourth edge after reset release. It then stays at 1.
- R4: After capture, changes on `strap_pad_in` have no effect on `mode_code[2:1]` until the next assertion of `rst_n` low.
- R5: `mode_code[0]` follows `sel_live` through a two-flop synchronizer. A change becomes visible after the second rising edge that samples it.
- R6: `test_mode` is 1 exactly when the straps have been captured and `mode_code` equals 3'b011.
- R7: In test mode a counter that starts at 0 on entry advances on every rising edge. `tclk_div[0]` is its bit 0, giving reference/2, and `tclk_div[1]` is its bit 1, giving reference/4. Outside test mode the counter is cleared one edge later, so `tclk_div` reads 0.
- R8: `tclk_ref` equals `clk_ref` AND a gate that is loaded from `test_mode` on each falling edge. In test mode it follows the reference clock; otherwise it stays low.
- R9: A new power-on reset captures the straps again, using the values present at the new capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| strap_pad_in | input | 2 | Input values of the shared strap pads |
| sel_live | input | 1 | Asynchronous live select bit |
| mode_code | output | 3 | {latched strap 1, latched strap 0, synchronized live select} |
| test_mode | output | 1 | Production test mode flag |
| pad_oe | output | 2 | Output enables of the shared pads |
| tclk_div | output | 2 | Test clocks: bit 0 is reference/2, bit 1 is reference/4 |
| tclk_ref | output | 1 | Gated reference clock in test mode |

## Verification
The bench builds the block with its defaults: two strap bits, two synchronizer stages and a two-bit divider. With these values all eight mode codes can be swept through full reset sequences. Each sequence checks the capture edge, the enable edge and the live-bit latency by edge count. A test-mode run then walks the divider through two full quarter-rate periods and probes the gated reference in both clock phases. The same run shows that strap changes after capture are ignored, and a final reset shows recapture.

// File: rtl/strap_mode_pkg.sv
package strap_mode_pkg;

  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_ARM    = 2'd1,
    PH_RUN    = 2'd2
  } cap_phase_e;

  // Test code: live bit and lowest strap high, all higher straps low.
  function automatic logic is_test_code(input logic [7:0] code, input int code_w);
    logic hit;
    hit = code[0] & code[1];
    for (int i = 2; i < 8; i++) begin
      if (i < code_w) hit = hit & ~code[i];
    end
    return hit;
  endfunction

endpackage

// File: rtl/strap_sync_chain.sv
module strap_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] stage_q;
  logic [LAST:0] stage_d;

  always_comb begin
    stage_d = {stage_q[LAST-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q = stage_q[LAST];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_mode_pkg::*;
#(
  parameter int STRAP_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] pad_in,
  output logic [STRAP_W-1:0] strap_q,
  output logic               captured,
  output logic [STRAP_W-1:0] pad_oe
);
  cap_phase_e        phase_q, phase_d;
  logic              load_en;
  logic [STRAP_W-1:0] strap_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_SAMPLE: phase_d = PH_ARM;
      PH_ARM:    phase_d = PH_RUN;
      default:   phase_d = PH_RUN;
    endcase
  end

  assign load_en = (phase_q == PH_SAMPLE);

  always_comb begin
    strap_d = strap_q;
    if (load_en) strap_d = pad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SAMPLE;
      strap_q <= '0;
    end else begin
      phase_q <= phase_d;
      strap_q <= strap_d;
    end
  end

  assign captured = (phase_q != PH_SAMPLE);
  assign pad_oe   = {STRAP_W{phase_q == PH_RUN}};
endmodule

// File: rtl/test_clk_gen.sv
module test_clk_gen #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_en,
  output logic [DIV_W-1:0] div_q,
  output logic             ref_out
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             gate_q;

  always_comb begin
    if (test_en) cnt_d = cnt_q + DIV_W'(1);
    else         cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Gate loaded while the clock is low, so the AND cannot glitch.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= test_en;
  end

  assign div_q   = cnt_q;
  assign ref_out = clk & gate_q;
endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl
  import strap_mode_pkg::*;
#(
  parameter int STRAP_W     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_pad_in,
  input  logic               sel_live,
  output logic [STRAP_W:0]   mode_code,
  output logic               test_mode,
  output logic [STRAP_W-1:0] pad_oe,
  output logic [DIV_W-1:0]   tclk_div,
  output logic               tclk_ref
);
  localparam int CODE_W = STRAP_W + 1;

  logic               rst_int_n;
  logic               live_s;
  logic               captured;
  logic [STRAP_W-1:0] strap_q;
  logic [7:0]         code_ext;

  strap_sync_chain #(.STAGES(2)) u_rst_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  strap_sync_chain #(.STAGES(SYNC_STAGES)) u_live_sync (
    .clk(clk_ref), .rst_n(rst_int_n), .d(sel_live), .q(live_s)
  );

  strap_capture #(.STRAP_W(STRAP_W)) u_cap (
    .clk(clk_ref), .rst_n(rst_int_n), .pad_in(strap_pad_in),
    .strap_q(strap_q), .captured(captured), .pad_oe(pad_oe)
  );

  assign mode_code = {strap_q, live_s};

  always_comb begin
    code_ext = '0;
    code_ext[CODE_W-1:0] = mode_code;
  end

  assign test_mode = captured & is_test_code(code_ext, CODE_W);

  test_clk_gen #(.DIV_W(DIV_W)) u_tclk (
    .clk(clk_ref), .rst_n(rst_int_n), .test_en(test_mode),
    .div_q(tclk_div), .ref_out(tclk_ref)
  );
endmodule

// File: rtl/strap_mode_chk.sv
module strap_mode_chk #(
  parameter int STRAP_W = 2,
  parameter int DIV_W   = 2
) (
  input logic               clk_ref,
  input logic               rst_n,
  input logic [STRAP_W:0]   mode_code,
  input logic               test_mode,
  input logic [STRAP_W-1:0] pad_oe,
  input logic [DIV_W-1:0]   tclk_div,
  input logic               captured
);
  // R1
  a_r1_oe_low_in_reset: assert property (@(posedge clk_ref)
    !rst_n |-> pad_oe == '0);

  // R4
  a_r4_straps_hold: assert property (@(posedge clk_ref) disable iff (!rst_n)
    captured && $past(captured) |-> $stable(mode_code[STRAP_W:1]));

  // R3
  a_r3_oe_after_capture: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(pad_oe[0]) |-> $past(captured));

  // R7
  a_r7_div_idle: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !test_mode |=> tclk_div == '0);

  // R7
  a_r7_half_toggles: assert property (@(posedge clk_ref) disable iff (!rst_n)
    test_mode && $past(test_mode) |-> tclk_div[0] != $past(tclk_div[0]));
endmodule

bind strap_mode_ctrl strap_mode_chk #(.STRAP_W(STRAP_W), .DIV_W(DIV_W)) u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .mode_code(mode_code), .test_mode(test_mode),
  .pad_oe(pad_oe), .tclk_div(tclk_div), .captured(captured)
);

// File: tb/strap_mode_ctrl_test.sv
`timescale 1ns/1ps
module strap_mode_ctrl_test;
  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic [1:0] strap_pad_in;
  logic       sel_live;
  logic [2:0] mode_code;
  logic       test_mode;
  logic [1:0] pad_oe;
  logic [1:0] tclk_div;
  logic       tclk_ref;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk_ref = ~clk_ref;

  strap_mode_ctrl uut (
    .clk_ref(clk_ref), .rst_n(rst_n), .strap_pad_in(strap_pad_in), .sel_live(sel_live),
    .mode_code(mode_code), .test_mode(test_mode), .pad_oe(pad_oe),
    .tclk_div(tclk_div), .tclk_ref(tclk_ref)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_reset(input logic [1:0] pads, input logic sel);
    @(negedge clk_ref);
    rst_n = 1'b0;
    strap_pad_in = pads;
    sel_live = sel;
    @(negedge clk_ref);
    @(negedge clk_ref);
    chk("R1 pad_oe in reset", pad_oe, 0);
    chk("R1 test_mode in reset", test_mode, 0);
    chk("R1 tclk_div in reset", tclk_div, 0);
    chk("R1 tclk_ref in reset", tclk_ref, 0);
    rst_n = 1'b1;
    @(posedge clk_ref); @(posedge clk_ref);
    @(negedge clk_ref);
    chk("R2 straps before capture", mode_code[2:1], 0);
    chk("R3 pad_oe before capture", pad_oe, 0);
    @(posedge clk_ref); @(negedge clk_ref);
    chk("R2 straps captured", mode_code[2:1], pads);
    chk("R3 pad_oe one cycle after capture", pad_oe, 0);
    @(posedge clk_ref); @(negedge clk_ref);
    chk("R3 pad_oe asserted", pad_oe, 3);
    chk("R5 live bit after sync", mode_code[0], sel);
    chk("R6 test flag from code", test_mode, ({pads, sel} == 3'b011) ? 1 : 0);
  endtask

  initial begin
    rst_n = 1'b0;
    strap_pad_in = 2'b00;
    sel_live = 1'b0;
    for (int c = 0; c < 8; c++) begin
      run_reset(2'(c >> 1), c[0]);
    end

    // Enter test mode through the live bit
    run_reset(2'b01, 1'b0);
    chk("R6 no test with live low", test_mode, 0);
    sel_live = 1'b1;
    @(posedge clk_ref); @(negedge clk_ref);
    chk("R5 live bit not yet through", mode_code[0], 0);
    @(posedge clk_ref); @(negedge clk_ref);
    chk("R5 live bit through", mode_code[0], 1);
    chk("R6 test entered", test_mode, 1);
    for (int k = 0; k < 8; k++) begin
      if (k != 0) @(negedge clk_ref);
      chk("R7 half-rate test clock", tclk_div[0], k % 2);
      chk("R7 quarter-rate test clock", tclk_div[1], (k / 2) % 2);
    end
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_ref); #1;
      chk("R8 gated ref high phase", tclk_ref, 1);
      @(negedge clk_ref); #1;
      chk("R8 gated ref low phase", tclk_ref, 0);
    end

    // Strap pads change after capture
    strap_pad_in = 2'b10;
    repeat (3) @(negedge clk_ref);
    chk("R4 straps ignore pad change", mode_code[2:1], 1);
    chk("R4 test stays on", test_mode, 1);

    // Leave test mode
    sel_live = 1'b0;
    @(posedge clk_ref); @(posedge clk_ref); @(negedge clk_ref);
    chk("R6 test left", test_mode, 0);
    @(posedge clk_ref); @(negedge clk_ref);
    chk("R7 dividers cleared", tclk_div, 0);
    @(posedge clk_ref); #1;
    chk("R8 gated ref held low", tclk_ref, 0);

    // Recapture with new pad values
    run_reset(2'b10, 1'b1);
    chk("R9 recaptured code", mode_code, 3'b101);
    chk("R9 no test after recapture", test_mode, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_ref);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule